// File: doc/BRIEF.md
# Lockable Watchdog Countdown Timer

This block watches over running software. Software picks a reload value, enables the watchdog and must then keep servicing it. On each cycle where the tick strobe from the slow, independent time base is high, a down-counter loses one count. If the counter runs out before software services it, the block raises a one-cycle system reset request. It then stays parked at zero until the system reset arrives.

Servicing means writing one fixed key value to the key register. That write reloads the counter. A write of a new reload value is held in a staging register and only takes effect at the next valid key write. The enable bit is sticky: software can set it but cannot clear it, so only a system reset turns the watchdog off. This keeps faulty software from disabling its own supervisor.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `rst_req` is low and the watchdog is disabled. While it stays disabled, no number of tick cycles produces a reset request.
- R2: Writing bit 0 = 1 at address 2 enables the watchdog. Any later write at address 2, including one with bit 0 = 0, leaves it enabled.
- R3: With an active reload value N, once the watchdog is enabled, `rst_req` is high in the cycle right after the N-th tick cycle. Tick cycles are counted from the enable write onward; a tick in the same cycle as the enable write does not count.
- R4: The counter changes only on cycles where `tick_en` is high. Cycles with `tick_en` low do not bring the timeout closer.
- R5: A write of 16'hAAAA at address 0 (the key) restarts the countdown. After it, N further tick cycles are needed to reach the request.
- R6: A write of any other value at address 0 is ignored and does not restart the countdown.
- R7: A value written at address 1 (the reload, low CNT_W bits) becomes the active reload only at the next valid key write. Until then the countdown keeps the old value.
- R8: A reload value of zero is stored as 1, so the timeout is never shorter than one tick.
- R9: `rst_req` is a single-cycle pulse. Afterwards the counter holds at zero: no further request is raised and key writes have no effect until system reset.
- R10: A system reset clears the enable, so a watchdog locked on before the reset stays silent afterwards.
- R11: If a valid key write and a tick fall in the same cycle, the key write wins. The countdown restarts and no request is produced in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 key, 1 reload, 2 control |
| wr_data | input | DATA_W | Write data |
| tick_en | input | 1 | One-cycle strobe from the independent slow time base |
| rst_req | output | 1 | Registered one-cycle system reset request |

## Verification
The bench builds the block with an 8-bit counter and a default reload of 12. This puts a full timeout within a few dozen cycles, so expiry, the post-expiry hold and the zero-to-one clamp are reached again and again in a short run. Random reload values stay at 15 or below, with zero allowed. Key, wrong-key and control writes are mixed in at random, so servicing races right at the last tick and staged reloads overtaken by later writes come up often.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WA_KEY  = 2'd0,
    WA_LOAD = 2'd1,
    WA_CTRL = 2'd2
  } wdog_addr_e;

  localparam int unsigned CTRL_EN_BIT = 0;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter logic [DATA_W-1:0] KEY = 16'hAAAA,
  parameter int unsigned DEF_LOAD = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_q,
  output logic              kick,
  output logic [CNT_W-1:0]  staged_q
);

  localparam logic [CNT_W-1:0] LOAD_RST =
    (DEF_LOAD == 0) ? CNT_W'(1) : CNT_W'(DEF_LOAD);

  logic [CNT_W-1:0] load_in;
  logic             sel_key, sel_load, sel_ctrl;

  assign sel_key  = wr_en && (wr_addr == WA_KEY);
  assign sel_load = wr_en && (wr_addr == WA_LOAD);
  assign sel_ctrl = wr_en && (wr_addr == WA_CTRL);

  assign kick = sel_key && (wr_data == KEY);

  // a zero timeout is never stored
  assign load_in = (wr_data[CNT_W-1:0] == '0) ? CNT_W'(1) : wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      staged_q <= LOAD_RST;
    end else begin
      // enable only ever sets; clearing needs system reset
      if (sel_ctrl && wr_data[CTRL_EN_BIT]) en_q <= 1'b1;
      if (sel_load) staged_q <= load_in;
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DEF_LOAD = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             kick,
  input  logic [CNT_W-1:0] staged,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);

  localparam logic [CNT_W-1:0] LOAD_RST =
    (DEF_LOAD == 0) ? CNT_W'(1) : CNT_W'(DEF_LOAD);

  logic [CNT_W-1:0] act_q;
  logic             dead_q;

  assign hit = en && !dead_q && !kick && tick_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= LOAD_RST;
      cnt_q  <= LOAD_RST;
      dead_q <= 1'b0;
    end else begin
      if (kick && !dead_q) act_q <= staged;
      if (!en) begin
        cnt_q <= kick ? staged : act_q;
      end else if (!dead_q) begin
        if (kick) begin
          cnt_q <= staged;
        end else if (tick_en) begin
          if (cnt_q == CNT_W'(1)) dead_q <= 1'b1;
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wdog_reqgen.sv
module wdog_reqgen (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic rst_req
);

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= hit;
  end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter logic [DATA_W-1:0] KEY = 16'hAAAA,
  parameter int unsigned DEF_LOAD = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick_en,
  output logic              rst_req
);

  logic             en_q;
  logic             kick;
  logic             hit;
  logic [CNT_W-1:0] staged_q;
  logic [CNT_W-1:0] cnt_q;

  wdog_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY), .DEF_LOAD(DEF_LOAD)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_q(en_q), .kick(kick), .staged_q(staged_q)
  );

  wdog_counter #(
    .CNT_W(CNT_W), .DEF_LOAD(DEF_LOAD)
  ) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .kick(kick), .staged(staged_q),
    .tick_en(tick_en), .cnt_q(cnt_q), .hit(hit)
  );

  wdog_reqgen u_req (
    .clk(clk), .rst(rst), .hit(hit), .rst_req(rst_req)
  );

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter logic [DATA_W-1:0] KEY = 16'hAAAA
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick_en,
  input logic              rst_req,
  input logic              en_q,
  input logic [CNT_W-1:0]  cnt_q
);

  logic key_wr;
  assign key_wr = wr_en && (wr_addr == 2'd0) && (wr_data == KEY);

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !rst_req);

  p_enable_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);

  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (rst)
    en_q && !tick_en && !key_wr |=> $stable(cnt_q));

  p_key_restarts_r5: assert property (@(posedge clk) disable iff (rst)
    en_q && (cnt_q != '0) && key_wr |=> (cnt_q != '0) && !rst_req);

  p_load_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (cnt_q != '0));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_zero_parks_r9: assert property (@(posedge clk) disable iff (rst)
    en_q && (cnt_q == '0) |=> (cnt_q == '0) && $stable(en_q));

  p_key_beats_tick_r11: assert property (@(posedge clk) disable iff (rst)
    en_q && (cnt_q == CNT_W'(1)) && key_wr && tick_en |=> !rst_req);

endmodule

bind wdog_guard wdog_guard_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tick_en(tick_en), .rst_req(rst_req),
  .en_q(en_q), .cnt_q(cnt_q)
);

// File: tb/wdog_guard_test.sv
module wdog_guard_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DW = 16;
  localparam int unsigned CW = 8;
  localparam int unsigned DEF = 12;
  localparam logic [DW-1:0] KEYV = 16'hAAAA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic          tick_en = 1'b0;
  logic          rst_req;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  bit m_en, m_dead, m_req;
  int m_cnt, m_act, m_stg;

  wdog_guard #(.DATA_W(DW), .CNT_W(CW), .KEY(KEYV), .DEF_LOAD(DEF)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_en(tick_en), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  function automatic int clamp_load(logic [DW-1:0] d);
    int v;
    v = int'(d[CW-1:0]);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_dead = 0; m_req = 0;
    m_cnt = DEF; m_act = DEF; m_stg = DEF;
  endtask

  task automatic model_step(bit we, logic [1:0] a, logic [DW-1:0] d, bit tk);
    bit kick, hit;
    int stg0;
    kick = we && a == 2'd0 && d == KEYV;
    hit  = m_en && !m_dead && !kick && tk && m_cnt == 1;
    stg0 = m_stg;
    if (kick && !m_dead) m_act = stg0;
    if (!m_en) m_cnt = kick ? stg0 : m_act;
    else if (!m_dead) begin
      if (kick) m_cnt = stg0;
      else if (tk) begin
        if (m_cnt == 1) m_dead = 1;
        m_cnt = m_cnt - 1;
      end
    end
    m_req = hit;
    if (we && a == 2'd1) m_stg = clamp_load(d);
    if (we && a == 2'd2 && d[0]) m_en = 1;
  endtask

  // one clock: drive at negedge, compare just after posedge
  task automatic step(bit we, logic [1:0] a, logic [DW-1:0] d, bit tk, string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick_en = tk;
    @(posedge clk);
    model_step(we, a, d, tk);
    #1;
    check(rst_req === m_req, m_req ? "R3" : tag, int'(rst_req), int'(m_req));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_en = 0; tick_en = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  // counts tick cycles until the request is seen
  task automatic measure(output int n, input string tag);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      step(0, 2'd0, '0, 1, tag);
      n++;
      if (rst_req) return;
    end
    n = -1;
  endtask

  task automatic quiet(int cycles, bit tk, string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      step(0, 2'd0, '0, tk, tag);
      if (rst_req) seen = 1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    model_reset();
    do_reset();

    // R1 reset state and silence while disabled
    #1 check(rst_req === 1'b0, "R1", int'(rst_req), 0);
    quiet(40, 1, "R1");

    // R3 default timeout; R9 pulse then park
    step(1, 2'd2, 16'h0001, 0, "R2");
    measure(n, "R3"); check(n == DEF, "R3", n, DEF);
    step(0, 2'd0, '0, 1, "R9");
    check(rst_req === 1'b0, "R9", int'(rst_req), 0);
    step(1, 2'd0, KEYV, 0, "R9");
    quiet(30, 1, "R9");

    // R4 ticks only every other cycle
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R4");
    n = 0;
    for (int i = 0; i < 200 && !rst_req; i++) begin
      step(0, 2'd0, '0, (i % 2) == 1, "R4");
      n++;
    end
    check(n == 2 * DEF, "R4", n, 2 * DEF);

    // R5 valid key restarts
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R5");
    for (int i = 0; i < 8; i++) step(0, 2'd0, '0, 1, "R5");
    step(1, 2'd0, KEYV, 0, "R5");
    measure(n, "R5"); check(n == DEF, "R5", n, DEF);

    // R6 wrong key ignored
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R6");
    for (int i = 0; i < 8; i++) step(0, 2'd0, '0, 1, "R6");
    step(1, 2'd0, 16'h5555, 0, "R6");
    measure(n, "R6"); check(n == DEF - 8, "R6", n, DEF - 8);

    // R7 staged reload waits for key
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R7");
    step(1, 2'd1, 16'd5, 0, "R7");
    measure(n, "R7"); check(n == DEF, "R7", n, DEF);
    do_reset();
    step(1, 2'd1, 16'd5, 0, "R7");
    step(1, 2'd0, KEYV, 0, "R7");
    step(1, 2'd2, 16'h0001, 0, "R7");
    measure(n, "R7"); check(n == 5, "R7", n, 5);

    // R8 zero clamps to one
    do_reset();
    step(1, 2'd1, 16'd0, 0, "R8");
    step(1, 2'd0, KEYV, 0, "R8");
    step(1, 2'd2, 16'h0001, 0, "R8");
    measure(n, "R8"); check(n == 1, "R8", n, 1);

    // R2 control write of zero cannot disable
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R2");
    step(1, 2'd2, 16'h0000, 0, "R2");
    measure(n, "R2"); check(n == DEF, "R2", n, DEF);

    // R10 system reset clears the lock
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R10");
    for (int i = 0; i < 5; i++) step(0, 2'd0, '0, 1, "R10");
    do_reset();
    quiet(40, 1, "R10");

    // R11 key beats tick on the last count
    do_reset();
    step(1, 2'd2, 16'h0001, 0, "R11");
    for (int i = 0; i < DEF - 1; i++) step(0, 2'd0, '0, 1, "R11");
    step(1, 2'd0, KEYV, 1, "R11");
    check(rst_req === 1'b0, "R11", int'(rst_req), 0);
    measure(n, "R11"); check(n == DEF, "R11", n, DEF);

    // random mix against the reference model
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [1:0] a;
      logic [DW-1:0] d;
      r = int'($urandom_range(99));
      a = 2'($urandom_range(3));
      d = (a == 2'd1) ? DW'($urandom_range(15))
        : ($urandom_range(1) == 1 ? KEYV : DW'($urandom_range(65535)));
      if (r < 1 && i > 0) do_reset();
      else step(r < 12, a, d, $urandom_range(3) != 0, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule